// File: doc/BRIEF.md
# Transmit FIFO Burst Reader

This block drains write data from a user-side transmit FIFO for a storage write command. A command gives a length counted in 512-byte sectors. For each sector the block reads one fixed burst of `BURST_BEATS` words back to back, with 32 words of 128 bits at the defaults. It forwards every word on a valid/data stream toward the packet builder, and it holds `busy` high until the whole length has been read and forwarded.

The block uses only the FIFO read count for flow control. A burst starts only when the count shows that a full burst is already stored and the downstream stage is ready. Read data comes back one cycle after each read enable, and the block passes it straight through onto the output stream. The output stream has one back-pressure rule: `out_ready` is sampled only in the cycle that decides whether a new burst starts. Once a burst has begun, all of its beats are sent on consecutive cycles whatever `out_ready` does. The downstream stage must therefore keep room for a whole burst whenever it shows ready. A user FIFO whose count is narrower than `CNT_W` must drive its unused upper count bits with 0.

Top module: `txb_burst_reader`

## Requirements
- R1: After reset, `busy`, `fifo_rd_en` and `out_valid` are low and `out_data` is zero.
- R2: A burst starts only after a cycle in which bits [CNT_W-1 : log2(BURST_BEATS)] of `fifo_count` are not all zero (bits [15:5] at the defaults), meaning at least `BURST_BEATS` words are stored. A count of `BURST_BEATS`-1 holds the block waiting.
- R3: In each burst, `fifo_rd_en` is high for exactly `BURST_BEATS` consecutive cycles and drops in the cycle after the last word has been requested.
- R4: `out_valid` is high in exactly the cycles that follow a cycle with `fifo_rd_en` high. In those cycles `out_data` equals `fifo_rd_data`, so words leave in FIFO order.
- R5: `out_ready` low in the deciding cycle stops a new burst from starting. `out_ready` falling during a burst does not stop or shorten that burst.
- R6: A command of N sectors produces exactly N×`BURST_BEATS` output beats. `busy` falls in the cycle right after the last beat is forwarded.
- R7: `fifo_empty` has no effect. A burst proceeds when the count allows it, even if `fifo_empty` is high.
- R8: `cmd_start` is ignored while `busy` is high. A command with `cmd_sectors` = 0 is ignored, and `busy` stays low.
- R9: `out_data` is zero in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle command pulse, accepted only while idle |
| cmd_sectors | input | LEN_W | Command length in 512-byte sectors |
| busy | output | 1 | High from command acceptance until the last beat is forwarded |
| fifo_count | input | CNT_W | Number of words stored in the user transmit FIFO |
| fifo_empty | input | 1 | FIFO empty flag, ignored |
| fifo_rd_en | output | 1 | FIFO read enable |
| fifo_rd_data | input | DATA_W | FIFO read data, valid the cycle after `fifo_rd_en` |
| out_valid | output | 1 | Output beat valid |
| out_data | output | DATA_W | Output beat data, zero when not valid |
| out_ready | input | 1 | Downstream ready, sampled only between bursts |

## Verification
The bench builds the block with `BURST_BEATS` = 8, `DATA_W` = 32, `LEN_W` = 8 and `CNT_W` = 16. With these values the burst gate sits at bit 3 of the count, so the boundary between 7 and 8 stored words can be reached with small pushes. Multi-burst commands, mid-burst drops of ready and ignored commands each fit in a few dozen cycles, and every beat's data and order is checked against a counting FIFO model.

// File: rtl/txb_pkg.sv
package txb_pkg;

  typedef enum logic [1:0] {
    TXB_IDLE  = 2'd0,
    TXB_WAIT  = 2'd1,
    TXB_BURST = 2'd2,
    TXB_TAIL  = 2'd3
  } txb_state_e;

endpackage

// File: rtl/txb_fill_gate.sv
module txb_fill_gate #(
  parameter int CNT_W  = 16,
  parameter int BEAT_W = 5
) (
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             down_ready,
  output logic             start_ok
);

  logic full_burst_stored;

  // A power-of-two burst is stored exactly when any bit above the burst index is set.
  assign full_burst_stored = |fifo_count[CNT_W-1:BEAT_W];
  assign start_ok          = full_burst_stored && down_ready;

endmodule

// File: rtl/txb_beat_ctr.sv
module txb_beat_ctr #(
  parameter int BURST_BEATS = 32,
  localparam int BEAT_W     = $clog2(BURST_BEATS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);

  logic [BEAT_W-1:0] beat_idx;

  assign last = run && (beat_idx == BEAT_W'(BURST_BEATS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_idx <= '0;
    end else if (run) begin
      beat_idx <= last ? '0 : beat_idx + 1'b1;
    end
  end

  // R3: a burst never ends early
  assert_burst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last) |=> run);

  // R3: the read enable drops right after the final request
  assert_burst_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && last) |=> !run);

endmodule

// File: rtl/txb_sector_ctr.sv
module txb_sector_ctr #(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             rem_one
);

  logic [LEN_W-1:0] remaining;

  assign rem_one = (remaining == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
    end else if (load) begin
      remaining <= load_val;
    end else if (dec) begin
      remaining <= remaining - 1'b1;
    end
  end

  // R6: the sector count never wraps below zero
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (remaining != '0));

endmodule

// File: rtl/txb_out_stage.sv
module txb_out_stage #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic beat_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) beat_pending <= 1'b0;
    else        beat_pending <= rd_en;
  end

  assign out_valid = beat_pending;
  assign out_data  = beat_pending ? rd_data : '0;

endmodule

// File: rtl/txb_burst_reader.sv
module txb_burst_reader
  import txb_pkg::*;
#(
  parameter int DATA_W      = 128,
  parameter int CNT_W       = 16,
  parameter int BURST_BEATS = 32,
  parameter int LEN_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [LEN_W-1:0]  cmd_sectors,
  output logic              busy,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              fifo_empty,
  output logic              fifo_rd_en,
  input  logic [DATA_W-1:0] fifo_rd_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);

  localparam int BEAT_W = $clog2(BURST_BEATS);

  txb_state_e state, state_nx;
  logic       start_ok;
  logic       burst_last;
  logic       rem_one;
  logic       cmd_take;
  logic       sector_done;

  assign cmd_take    = (state == TXB_IDLE) && cmd_start && (cmd_sectors != '0);
  assign sector_done = burst_last;
  assign fifo_rd_en  = (state == TXB_BURST);
  assign busy        = (state != TXB_IDLE);

  txb_fill_gate #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_gate (
    .fifo_count (fifo_count),
    .down_ready (out_ready),
    .start_ok   (start_ok)
  );

  txb_beat_ctr #(.BURST_BEATS(BURST_BEATS)) u_beats (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (fifo_rd_en),
    .last  (burst_last)
  );

  txb_sector_ctr #(.LEN_W(LEN_W)) u_sectors (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd_take),
    .load_val (cmd_sectors),
    .dec      (sector_done),
    .rem_one  (rem_one)
  );

  txb_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (fifo_rd_en),
    .rd_data   (fifo_rd_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      TXB_IDLE:  if (cmd_take) state_nx = TXB_WAIT;
      TXB_WAIT:  if (start_ok) state_nx = TXB_BURST;
      TXB_BURST: if (burst_last) state_nx = rem_one ? TXB_TAIL : TXB_WAIT;
      TXB_TAIL:  state_nx = TXB_IDLE;
      default:   state_nx = TXB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= TXB_IDLE;
    else        state <= state_nx;
  end

  // R2 R5: a burst begins only after a cycle with a full burst stored and ready high
  assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_rd_en) |-> $past((fifo_count >= CNT_W'(BURST_BEATS)) && out_ready));

  // R2: the bit-slice gate agrees with a plain magnitude compare
  assert_gate_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> (fifo_count >= CNT_W'(BURST_BEATS)));

  // R7: the empty flag cannot hold off a burst the count allows
  assert_empty_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TXB_WAIT && start_ok && fifo_empty) |=> fifo_rd_en);

  // R6: busy falls only right after a forwarded beat
  assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_valid));

  // R8: a zero-length command leaves the block idle
  assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start && cmd_sectors == '0) |=> !busy);

endmodule

// File: tb/test_txb_burst_reader.sv
`timescale 1ns/1ps
module test_txb_burst_reader;

  localparam int DW = 32;
  localparam int CW = 16;
  localparam int BB = 8;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_start = 1'b0;
  logic [LW-1:0] cmd_sectors = '0;
  logic          busy;
  logic [CW-1:0] fifo_count;
  logic          fifo_empty = 1'b0;
  logic          fifo_rd_en;
  logic [DW-1:0] fifo_rd_data = 32'hDEAD_0001;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_ready = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // FIFO model: pushes come from tasks, pops from the read enable
  int pushed = 0;
  int popped = 0;
  logic [DW-1:0] word = 32'h100;
  assign fifo_count = CW'(pushed - popped);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fifo_rd_en === 1'b1) begin
      fifo_rd_data <= word;
      word         <= word + 1;
      popped       <= popped + 1;
    end
  end

  txb_burst_reader #(.DATA_W(DW), .CNT_W(CW), .BURST_BEATS(BB), .LEN_W(LW)) i_txb_burst_reader (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_sectors(cmd_sectors),
    .busy(busy), .fifo_count(fifo_count), .fifo_empty(fifo_empty),
    .fifo_rd_en(fifo_rd_en), .fifo_rd_data(fifo_rd_data),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Output monitor, sampled away from the active edge
  logic [DW-1:0] exp_word = 32'h100;
  int beats = 0;
  int rd_total = 0;
  int run_len = 0;
  int last_v = -1;
  logic prev_rd = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid || prev_rd)
        chk(out_valid == prev_rd, "R4 valid follows read", out_valid, prev_rd);
      if (out_valid) begin
        chk(out_data == exp_word, "R4 data order", out_data, exp_word);
        exp_word = exp_word + 1;
        beats++;
        last_v = cyc;
      end else if (out_data != '0) begin
        chk(1'b0, "R9 idle data", out_data, 0);
      end
      if (fifo_rd_en) begin
        run_len++;
        rd_total++;
      end else if (run_len != 0) begin
        chk(run_len == BB, "R3 burst length", run_len, BB);
        run_len = 0;
      end
      prev_rd = fifo_rd_en;
    end
  end

  task automatic push(input int n);
    @(negedge clk);
    pushed = pushed + n;
  endtask

  task automatic issue(input int n);
    @(negedge clk);
    cmd_start   = 1'b1;
    cmd_sectors = LW'(n);
    @(negedge clk);
    cmd_start   = 1'b0;
  endtask

  task automatic wait_done(input string req);
    while (busy) @(negedge clk);
    chk(cyc - last_v == 1, req, cyc - last_v, 1);
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(fifo_rd_en == 1'b0, "R1 rd_en", fifo_rd_en, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(out_data == '0, "R1 R9 out_data", out_data, 0);
  endtask

  task automatic t_basic;
    int b0 = beats;
    push(2 * BB);
    issue(2);
    wait_done("R6 busy after last beat");
    chk(beats - b0 == 2 * BB, "R6 beat total", beats - b0, 2 * BB);
  endtask

  task automatic t_gate;
    int b0 = beats;
    int r0 = rd_total;
    push(BB - 1);
    issue(1);
    repeat (20) @(negedge clk);
    chk(rd_total - r0 == 0, "R2 hold below burst", rd_total - r0, 0);
    chk(busy == 1'b1, "R2 still busy", busy, 1);
    push(1);
    wait_done("R6 busy after gated burst");
    chk(beats - b0 == BB, "R2 burst after fill", beats - b0, BB);
  endtask

  task automatic t_ready;
    int b0 = beats;
    int r0 = rd_total;
    out_ready = 1'b0;
    push(2 * BB);
    issue(2);
    repeat (10) @(negedge clk);
    chk(rd_total - r0 == 0, "R5 ready low holds start", rd_total - r0, 0);
    out_ready = 1'b1;
    while (!fifo_rd_en) @(negedge clk);
    out_ready = 1'b0;
    repeat (15) @(negedge clk);
    chk(beats - b0 == BB, "R5 burst finishes without ready", beats - b0, BB);
    chk(busy == 1'b1, "R5 second burst held", busy, 1);
    out_ready = 1'b1;
    wait_done("R6 busy after ready test");
    chk(beats - b0 == 2 * BB, "R5 total", beats - b0, 2 * BB);
  endtask

  task automatic t_empty;
    int b0 = beats;
    fifo_empty = 1'b1;
    push(BB);
    issue(1);
    wait_done("R6 busy with empty high");
    chk(beats - b0 == BB, "R7 empty flag ignored", beats - b0, BB);
    fifo_empty = 1'b0;
  endtask

  task automatic t_busy_ignore;
    int b0 = beats;
    push(BB);
    issue(1);
    @(negedge clk);
    cmd_start   = 1'b1;
    cmd_sectors = LW'(5);
    @(negedge clk);
    cmd_start   = 1'b0;
    wait_done("R6 busy in ignore test");
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R8 no late command", busy, 0);
    chk(beats - b0 == BB, "R8 busy start ignored", beats - b0, BB);
  endtask

  task automatic t_zero;
    int r0 = rd_total;
    issue(0);
    chk(busy == 1'b0, "R8 zero length", busy, 0);
    repeat (5) @(negedge clk);
    chk(rd_total - r0 == 0, "R8 zero length no read", rd_total - r0, 0);
  endtask

  task automatic t_long;
    int b0 = beats;
    push(3 * BB);
    issue(3);
    wait_done("R6 busy after long command");
    chk(beats - b0 == 3 * BB, "R6 three sectors", beats - b0, 3 * BB);
    chk(out_data == '0, "R9 quiet after command", out_data, 0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_gate();
    t_ready();
    t_empty();
    t_busy_ignore();
    t_zero();
    t_long();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule